// File: doc/BRIEF.md
# PCIe Read Request Splitter

This block sits between a DMA engine and the request path of a PCIe endpoint. It accepts a single read command, made of a start address and a byte count, and turns it into a sequence of memory read request descriptors. Each descriptor carries an address, a length in dwords and a tag. Every descriptor respects the maximum read request size programmed through a 3-bit size code, and no descriptor crosses a 4 KB address boundary.

Requests in flight are limited by a small pool of tags. Tags are handed out in strict round-robin order. When the next tag in that order is still outstanding, the request stream pauses until a completion-done indication returns that tag. The size code is captured when a command is accepted. A new command may be taken as soon as every chunk of the current one has been issued. A busy flag covers the whole life of a command, up to the moment its last tag comes back.

Control is a three-state machine. IDLE means no work and all tags free. SPLIT means chunks of the current command remain to be issued. DRAIN means every chunk has been issued and tags may still be outstanding. The transitions are:
- IDLE→SPLIT on command accept.
- SPLIT→DRAIN when the final chunk is accepted downstream.
- DRAIN→SPLIT on command accept.
- DRAIN→IDLE once the tag pool is seen empty.

Top module: `rrs_read_splitter`

## Requirements
- R1: The size code selects a limit of 128 << code bytes for codes 0 to 5 (0=128, 1=256, 2=512, 3=1024, 4=2048, 5=4096). No request length exceeds that limit.
- R2: Size codes 6 and 7 are treated as 128 bytes.
- R3: The first request ends at the next address aligned to the size limit. Middle requests are full size. The last request carries the remainder. Request addresses are contiguous, and the lengths sum to the command length.
- R4: No request spans a 4096-byte aligned address boundary.
- R5: req_len_dw equals the request byte count divided by 4. Command lengths are nonzero multiples of 4 bytes, and addresses are dword aligned.
- R6: Tags are issued as 0,1,...,NTAGS-1,0,... The sequence continues across commands, and a tag is issued again only after its completion-done has been received.
- R7: req_valid is low while the next tag in order is outstanding. It rises in the cycle after the completion-done for that tag.
- R8: While req_valid is high and req_ready is low, req_addr, req_len_dw and req_tag hold their values.
- R9: cmd_ready is low while chunks of the accepted command remain to be issued, and high otherwise, including while earlier tags are still outstanding.
- R10: busy is high from command accept until all chunks are issued and all tags are freed. It falls at the second clock edge after the final completion-done.
- R11: After reset, req_valid and busy are low, cmd_ready is high and the next tag is 0.
- R12: The size code is sampled when a command is accepted. Changing it while the command runs has no effect on that command.
- R13: A completion-done on one tag in the same cycle as a request accept on another tag updates both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrrs_code | input | 3 | Encoded maximum read request size |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_addr | input | ADDR_W | Command start byte address |
| cmd_len | input | LEN_W | Command byte count |
| req_valid | output | 1 | Request descriptor valid |
| req_ready | input | 1 | Downstream takes the descriptor |
| req_addr | output | ADDR_W | Request byte address |
| req_len_dw | output | 11 | Request length in dwords |
| req_tag | output | TAG_W | Request tag |
| cpl_done_valid | input | 1 | All completion data for a tag has arrived |
| cpl_done_tag | input | TAG_W | Tag being returned |
| busy | output | 1 | Command in progress or tags outstanding |

## Verification
Two functions can fall in the same cycle: returning a tag through completion-done and accepting a request that takes a different tag. The bench provokes this by returning the oldest outstanding tag in the very cycle it accepts a new request. It judges the result by the tag sequence that follows: the returned tag must come back in its round-robin turn with no extra stall, and the newly issued tag must block its own reuse. A second overlap is a command accept during DRAIN while earlier tags are still out. In that case the bench checks that the new command's tags continue the round-robin order and that busy never drops between the two commands.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    // byte width able to hold 4096
    localparam int SZ_W = 13;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPLIT = 2'd1,
        ST_DRAIN = 2'd2
    } rrs_state_e;

endpackage

// File: rtl/rrs_size_decode.sv
module rrs_size_decode
    import rrs_pkg::*;
(
    input  logic [2:0]      code,
    output logic [SZ_W-1:0] limit_bytes
);

    always_comb begin
        if (code > 3'd5) begin
            limit_bytes = SZ_W'(128);
        end else begin
            limit_bytes = SZ_W'(128) << code;
        end
    end

endmodule

// File: rtl/rrs_chunk_calc.sv
module rrs_chunk_calc
    import rrs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [11:0]      addr_lo,
    input  logic [LEN_W-1:0] rem_bytes,
    input  logic [SZ_W-1:0]  limit_bytes,
    output logic [SZ_W-1:0]  chunk_bytes,
    output logic             chunk_last
);

    logic [11:0]      align_mask;
    logic [11:0]      offset;
    logic [SZ_W-1:0]  to_limit;
    logic [SZ_W-1:0]  to_page;
    logic [SZ_W-1:0]  room;
    logic [LEN_W-1:0] room_ext;

    always_comb begin
        align_mask = limit_bytes[11:0] - 12'd1;
        offset     = addr_lo & align_mask;
        to_limit   = limit_bytes - {1'b0, offset};
        to_page    = SZ_W'(4096) - {1'b0, addr_lo};
        room       = (to_limit < to_page) ? to_limit : to_page;
        room_ext   = LEN_W'(room);
        chunk_last = (rem_bytes <= room_ext);
        chunk_bytes = chunk_last ? SZ_W'(rem_bytes) : room;
    end

endmodule

// File: rtl/rrs_tag_pool.sv
module rrs_tag_pool #(
    parameter int NTAGS = 4,
    localparam int TAG_W = $clog2(NTAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             free_valid,
    input  logic [TAG_W-1:0] free_tag,
    output logic [TAG_W-1:0] next_tag,
    output logic             next_free,
    output logic [NTAGS-1:0] tag_busy,
    output logic             pool_empty
);

    logic [TAG_W-1:0] ptr_q;

    for (genvar g = 0; g < NTAGS; g++) begin : g_tag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_busy[g] <= 1'b0;
            end else if (alloc && (ptr_q == TAG_W'(g))) begin
                tag_busy[g] <= 1'b1;
            end else if (free_valid && (free_tag == TAG_W'(g))) begin
                tag_busy[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (alloc) begin
            ptr_q <= (ptr_q == TAG_W'(NTAGS - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_comb begin
        next_tag   = ptr_q;
        next_free  = !tag_busy[ptr_q];
        pool_empty = (tag_busy == '0);
    end

endmodule

// File: rtl/rrs_read_splitter.sv
module rrs_read_splitter
    import rrs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int NTAGS  = 4,
    localparam int TAG_W = $clog2(NTAGS),
    localparam int DW_W  = SZ_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mrrs_code,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DW_W-1:0]   req_len_dw,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              cpl_done_valid,
    input  logic [TAG_W-1:0]  cpl_done_tag,
    output logic              busy
);

    rrs_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [2:0]        code_q;

    logic [SZ_W-1:0]   mrrs_bytes;
    logic [SZ_W-1:0]   chunk_bytes;
    logic              chunk_last;
    logic [TAG_W-1:0]  next_tag;
    logic              next_free;
    logic [NTAGS-1:0]  tag_busy;
    logic              pool_empty;
    logic              cmd_fire;
    logic              req_fire;

    rrs_size_decode u_size (
        .code        (code_q),
        .limit_bytes (mrrs_bytes)
    );

    rrs_chunk_calc #(.LEN_W(LEN_W)) u_chunk (
        .addr_lo     (addr_q[11:0]),
        .rem_bytes   (rem_q),
        .limit_bytes (mrrs_bytes),
        .chunk_bytes (chunk_bytes),
        .chunk_last  (chunk_last)
    );

    rrs_tag_pool #(.NTAGS(NTAGS)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (req_fire),
        .free_valid (cpl_done_valid),
        .free_tag   (cpl_done_tag),
        .next_tag   (next_tag),
        .next_free  (next_free),
        .tag_busy   (tag_busy),
        .pool_empty (pool_empty)
    );

    assign cmd_fire = cmd_valid && cmd_ready;
    assign req_fire = req_valid && req_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_fire) state_d = ST_SPLIT;
            end
            ST_SPLIT: begin
                if (req_fire && chunk_last) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (cmd_fire)        state_d = ST_SPLIT;
                else if (pool_empty) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready  = (state_q != ST_SPLIT);
        busy       = (state_q != ST_IDLE);
        req_valid  = (state_q == ST_SPLIT) && next_free;
        req_addr   = addr_q;
        req_len_dw = chunk_bytes[SZ_W-1:2];
        req_tag    = next_tag;
    end

    // command cursor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            code_q <= '0;
        end else if (cmd_fire) begin
            addr_q <= cmd_addr;
            rem_q  <= cmd_len;
            code_q <= mrrs_code;
        end else if (req_fire) begin
            addr_q <= addr_q + ADDR_W'(chunk_bytes);
            rem_q  <= rem_q - LEN_W'(chunk_bytes);
        end
    end

endmodule

// File: rtl/rrs_read_splitter_chk.sv
module rrs_read_splitter_chk
    import rrs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NTAGS  = 4,
    localparam int TAG_W = $clog2(NTAGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [SZ_W-3:0]   req_len_dw,
    input logic [TAG_W-1:0]  req_tag,
    input logic              cmd_ready,
    input logic              busy,
    input logic [NTAGS-1:0]  tag_busy,
    input logic [SZ_W-1:0]   mrrs_bytes
);

    // R1
    len_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len_dw != '0) && ({req_len_dw, 2'b00} <= mrrs_bytes));

    // R4
    page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({2'b00, req_addr[11:0]} + {1'b0, req_len_dw, 2'b00}) <= 14'd4096);

    // R7
    tag_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !tag_busy[req_tag]);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_addr)
                                      && $stable(req_len_dw) && $stable(req_tag));

    // R9
    cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !cmd_ready && busy);

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cmd_ready && !req_valid && (tag_busy == '0));

endmodule

bind rrs_read_splitter rrs_read_splitter_chk #(
    .ADDR_W (ADDR_W),
    .NTAGS  (NTAGS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len_dw (req_len_dw),
    .req_tag    (req_tag),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .tag_busy   (tag_busy),
    .mrrs_bytes (mrrs_bytes)
);

// File: tb/rrs_read_splitter_tb_top.sv
module rrs_read_splitter_tb_top;

    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mrrs_code = 3'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr;
    logic [10:0] req_len_dw;
    logic [1:0]  req_tag;
    logic        cpl_done_valid = 1'b0;
    logic [1:0]  cpl_done_tag = '0;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    int q_tag [0:7];
    int q_head = 0;
    int q_cnt = 0;
    int exp_ptr = 0;

    always #4 clk = ~clk;

    rrs_read_splitter #(.ADDR_W(32), .LEN_W(16), .NTAGS(NT)) dut_i (
        .clk(clk), .rst_n(rst_n), .mrrs_code(mrrs_code),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len_dw(req_len_dw), .req_tag(req_tag),
        .cpl_done_valid(cpl_done_valid), .cpl_done_tag(cpl_done_tag),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic bit tag_out(input int t);
        for (int i = 0; i < q_cnt; i++) begin
            if (q_tag[(q_head + i) % 8] == t) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic pop_free();
        cpl_done_valid = 1'b1;
        cpl_done_tag   = 2'(q_tag[q_head]);
        q_head = (q_head + 1) % 8;
        q_cnt--;
    endtask

    // one command: bp = backpressure, eager = free alongside issue (R13),
    // drain = return all tags at the end, swap = change code mid-run (R12)
    task automatic run_cmd(input int addr, input int len, input int code,
                           input bit bp, input bit eager, input bit drain, input bit swap);
        int e_addr = addr;
        int e_rem  = len;
        int lim    = (code > 5) ? 128 : (128 << code);
        int cyc    = 0;
        bit freed_next = 1'b0;
        @(negedge clk);
        cpl_done_valid = 1'b0;
        chk(cmd_ready == 1'b1, "R9 accept", cmd_ready, 1);
        mrrs_code = 3'(code);
        cmd_addr  = addr;
        cmd_len   = 16'(len);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (swap) mrrs_code = 3'd5;
        while (e_rem > 0 && cyc < 3000) begin
            bit rdy;
            cyc++;
            cpl_done_valid = 1'b0;
            rdy = bp ? cyc[0] : 1'b1;
            req_ready = rdy;
            chk(busy == 1'b1, "R10 busy in split", busy, 1);
            chk(cmd_ready == 1'b0, "R9 blocked", cmd_ready, 0);
            if (freed_next) chk(req_valid == 1'b1, "R7 resume", req_valid, 1);
            freed_next = 1'b0;
            if (q_cnt == NT) chk(req_valid == 1'b0, "R7 stall", req_valid, 0);
            if (req_valid) begin
                int ch = lim - (e_addr % lim);
                if (e_rem < ch) ch = e_rem;
                chk(req_addr == 32'(e_addr), "R3 addr", req_addr, e_addr);
                chk(req_len_dw == 11'(ch / 4), (code > 5) ? "R2 len" : "R1 R5 len", req_len_dw, ch / 4);
                chk(req_tag == 2'(exp_ptr), "R6 tag", req_tag, exp_ptr);
                chk((req_addr % 4096) + req_len_dw * 4 <= 4096, "R4 page", req_addr % 4096, 0);
                if (rdy) begin
                    if (eager && q_cnt >= 2) pop_free();
                    q_tag[(q_head + q_cnt) % 8] = exp_ptr;
                    q_cnt++;
                    exp_ptr = (exp_ptr + 1) % NT;
                    e_addr += ch;
                    e_rem  -= ch;
                end
            end else if (q_cnt == NT) begin
                pop_free();
                freed_next = 1'b1;
            end else if (!tag_out(exp_ptr)) begin
                chk(1'b0, "R7 idle with free tag", 0, 1);
            end
            @(negedge clk);
        end
        cpl_done_valid = 1'b0;
        req_ready = 1'b1;
        chk(e_rem == 0, "R3 completion of split", e_rem, 0);
        chk(cmd_ready == 1'b1, "R9 drain accept", cmd_ready, 1);
        chk(busy == 1'b1, "R10 busy in drain", busy, 1);
        if (drain) begin
            while (q_cnt > 0) begin
                pop_free();
                @(negedge clk);
                cpl_done_valid = 1'b0;
                chk(busy == 1'b1, "R10 busy until empty", busy, 1);
            end
            @(negedge clk);
            chk(busy == 1'b0, "R10 busy falls", busy, 0);
            chk(req_valid == 1'b0, "R10 idle valid", req_valid, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R11 valid", req_valid, 0);
        chk(busy == 1'b0, "R11 busy", busy, 0);
        chk(cmd_ready == 1'b1, "R11 cmd_ready", cmd_ready, 1);
        chk(req_tag == 2'd0, "R11 tag", req_tag, 0);
    endtask

    task automatic t_stall_split();   // R1 R6 R7: eight 128-byte chunks, four tags
        run_cmd(32'h1000, 1024, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_unaligned_bp();  // R3 R8
        run_cmd(32'h1F40, 600, 1, 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_page();          // R4
        run_cmd(32'h0FC0, 512, 5, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reserved();      // R2
        run_cmd(32'h2000, 384, 6, 1'b0, 1'b0, 1'b1, 1'b0);
        run_cmd(32'h2200, 256, 7, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_code_change();   // R12
        run_cmd(32'h3000, 1024, 2, 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_exact_single();  // R3 R5
        run_cmd(32'h0800, 1024, 3, 1'b0, 1'b0, 1'b1, 1'b0);
        run_cmd(32'h0400, 8, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_overlap();       // R9 R13
        run_cmd(32'h5000, 8192, 5, 1'b0, 1'b1, 1'b0, 1'b0);
        run_cmd(32'h7F80, 768, 0, 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_stall_split();
        t_unaligned_bp();
        t_page();
        t_reserved();
        t_code_change();
        t_exact_single();
        t_overlap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule